// File: doc/BRIEF.md
# Graded Reset Action Hub

This block sits between the sources of reset events in a system and a set of downstream subsystems. It turns each event into a reset action for each subsystem. The action levels are graded. A hard reset returns the subsystem to a known state. An abort stops the subsystem and clears part of its state. A halt freezes the subsystem and leaves its state alone. An event can also map to no action.

The hardware events are brown-out, watchdog expiry, a critical sensor alarm and a user pushbutton. Firmware adds one more event of its own. A programmable table assigns each event its own level for every subsystem, so one event can act on different subsystems at different levels.

Power-on bypasses the table and always hard-resets every subsystem. The power-on reset works with no clock running. Firmware can also:
- raise any level directly on any subsystem,
- fire an asynchronous hard reset on chosen subsystems,
- request a full power-on restart.

The synchronous actions are qualified by an enable input.

Each subsystem gets three outputs:
- an active-low hard reset, which asserts at once and releases through a two-stage synchronizer followed by a fixed hold time,
- a one-cycle abort pulse,
- a halt level that stays set until firmware clears it.

Top module: `reset_action_hub`

## Requirements
- R1: Action levels are encoded as 0 none, 1 halt, 2 abort, 3 hard. Map rows sit at register addresses 0 to 4, for brown-out, watchdog, sensor, pushbutton and firmware event in that order. Subsystem s uses bits [2s+1:2s] of a row. A row reads back on `regRdata` while `regAddr` selects it. Every row resets to all ones, which means hard on every subsystem.
- R2: An event input (`sysEvt` bit 0 brown-out, 1 watchdog, 2 sensor, 3 pushbutton) that is high at a clock edge applies its row's level to each subsystem at that edge. When several sources are active in the same cycle, each subsystem takes the most severe level: hard > abort > halt > none.
- R3: A synchronous hard action drives `subHardRstN` low from that edge for exactly 16 cycles and clears the subsystem's halt.
- R4: An abort action raises `subAbort` for exactly one cycle after the edge.
- R5: A halt action sets `subHalt`, and it stays set until firmware clears it or a hard reset occurs.
- R6: While `syncEn` is low, every event-driven and firmware-driven synchronous hard, abort and halt action is ignored.
- R7: A write to address 8 commands actions directly. Bits [N-1:0] request hard, [2N-1:N] request abort, [3N-1:2N] request halt, and [4N-1:3N] clear halt. Clearing halt does not depend on `syncEn`. A write of bit 0 = 1 to address 11 raises the firmware event, which acts through row 4.
- R8: When `porN` is low, every `subHardRstN` goes low at once, even with the clock stopped. Abort and halt clear, and the map returns to its default. After `porN` rises, each reset releases after two synchronizer cycles plus the 16-cycle hold.
- R9: A write to address 9 with a subsystem mask asserts those subsystems' hard resets asynchronously at the write edge, whatever the value of `syncEn`. The reset is held through the next edge and released through the synchronizer plus hold, giving 19 cycles low in total.
- R10: A write of bit 0 = 1 to address 10 restarts the system. Every subsystem gets the R9 treatment, and the map rows return to their defaults. Hard resets requested through addresses 8 or 9 leave the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| syncEn | input | 1 | Enable that qualifies synchronous actions |
| sysEvt | input | 4 | Hardware event requests, one per bit |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 8 | Map row selected by regAddr |
| subHardRstN | output | 4 | Active-low hard reset per subsystem |
| subAbort | output | 4 | One-cycle abort pulse per subsystem |
| subHalt | output | 4 | Halt level per subsystem |

## Verification
Most internal faults in this block appear at the subsystem outputs within one clock edge:
- A corrupted map row or a wrong severity ranking gives the wrong mix of reset, abort and halt at the very edge where the event is sampled.
- A fault in the hold counter or the synchronizer changes when `subHardRstN` is released. That can only be seen 16 to 19 cycles later, so every release edge is compared against the reference model.
- A halt that was lost or left stuck stays wrong until the next clear or hard reset, so the checks hold halts for many cycles before clearing them.

// File: rtl/reset_action_pkg.sv
package reset_action_pkg;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_HALT  = 2'd1,
    LVL_ABORT = 2'd2,
    LVL_HARD  = 2'd3
  } level_e;

  // per-subsystem strobes from control to datapath
  typedef struct packed {
    logic hard;
    logic abort;
    logic haltSet;
    logic haltClr;
  } strobe_t;

  localparam int unsigned ADDR_CMD   = 8;
  localparam int unsigned ADDR_ASYNC = 9;
  localparam int unsigned ADDR_POR   = 10;
  localparam int unsigned ADDR_FWEVT = 11;

endpackage

// File: rtl/rah_ctrl.sv
module rah_ctrl
  import reset_action_pkg::*;
#(
  parameter int NUM_SUBS = 4,
  parameter int NUM_EVT  = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  porN,
  input  logic                  syncEn,
  input  logic [NUM_EVT-1:0]    sysEvt,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [4*NUM_SUBS-1:0] regWdata,
  output logic [2*NUM_SUBS-1:0] regRdata,
  output strobe_t               strobes [NUM_SUBS],
  output logic [NUM_SUBS-1:0]   asyncHit
);

  localparam int ROWS  = NUM_EVT + 1;
  localparam int MAP_W = 2 * NUM_SUBS;

  logic [MAP_W-1:0]    mapQ [ROWS];
  logic [NUM_SUBS-1:0] asyncPulseQ;
  logic                porPulseQ;

  logic wrCmd, wrAsync, wrPor, wrFwEvt;
  logic [ROWS-1:0] evtAll;

  assign wrCmd   = regWe && (regAddr == ADDR_W'(ADDR_CMD));
  assign wrAsync = regWe && (regAddr == ADDR_W'(ADDR_ASYNC));
  assign wrPor   = regWe && (regAddr == ADDR_W'(ADDR_POR))   && regWdata[0];
  assign wrFwEvt = regWe && (regAddr == ADDR_W'(ADDR_FWEVT)) && regWdata[0];
  assign evtAll  = {wrFwEvt, sysEvt};

  // map rows: cleared by power-on only (pin or firmware restart)
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int r = 0; r < ROWS; r++) mapQ[r] <= '1;
    end else if (wrPor) begin
      for (int r = 0; r < ROWS; r++) mapQ[r] <= '1;
    end else if (regWe) begin
      for (int r = 0; r < ROWS; r++)
        if (regAddr == ADDR_W'(r)) mapQ[r] <= regWdata[MAP_W-1:0];
    end
  end

  // one-cycle pulses that feed the asynchronous reset of the outputs
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      asyncPulseQ <= '0;
      porPulseQ   <= 1'b0;
    end else begin
      asyncPulseQ <= wrAsync ? regWdata[NUM_SUBS-1:0] : '0;
      porPulseQ   <= wrPor;
    end
  end

  assign asyncHit = asyncPulseQ | {NUM_SUBS{(~porN) | porPulseQ}};

  // severity resolution per subsystem
  always_comb begin
    for (int s = 0; s < NUM_SUBS; s++) begin
      level_e lvl;
      lvl = LVL_NONE;
      for (int r = 0; r < ROWS; r++)
        if (evtAll[r] && (mapQ[r][2*s +: 2] > lvl)) lvl = level_e'(mapQ[r][2*s +: 2]);
      if (wrCmd) begin
        if (regWdata[s]) lvl = LVL_HARD;
        else if (regWdata[NUM_SUBS + s] && (lvl < LVL_ABORT)) lvl = LVL_ABORT;
        else if (regWdata[2*NUM_SUBS + s] && (lvl < LVL_HALT)) lvl = LVL_HALT;
      end
      if (!syncEn) lvl = LVL_NONE;
      strobes[s].hard    = (lvl == LVL_HARD);
      strobes[s].abort   = (lvl == LVL_ABORT);
      strobes[s].haltSet = (lvl == LVL_HALT);
      strobes[s].haltClr = wrCmd && regWdata[3*NUM_SUBS + s];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int r = 0; r < ROWS; r++)
      if (regAddr == ADDR_W'(r)) regRdata = mapQ[r];
  end

  for (genvar g = 0; g < NUM_SUBS; g++) begin : gAssert
    assert_gate_R6: assert property (@(posedge clk) disable iff (!porN)
      !syncEn |-> !(strobes[g].hard || strobes[g].abort || strobes[g].haltSet));
    assert_fw_hard_R7: assert property (@(posedge clk) disable iff (!porN)
      (syncEn && wrCmd && regWdata[g]) |-> strobes[g].hard);
    assert_async_R9: assert property (@(posedge clk) disable iff (!porN)
      (wrAsync && regWdata[g]) |=> asyncHit[g]);
  end
  for (genvar r = 0; r < ROWS; r++) begin : gMapAssert
    assert_por_map_R10: assert property (@(posedge clk) disable iff (!porN)
      wrPor |=> (mapQ[r] == '1));
  end

endmodule

// File: rtl/rah_sub_chan.sv
module rah_sub_chan
  import reset_action_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic    clk,
  input  logic    aRst,
  input  strobe_t stb,
  output logic    rstNOut,
  output logic    abortOut,
  output logic    haltOut
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             sync1Q, sync2Q;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             rstNQ, abortQ, haltQ;

  always_comb begin
    if (stb.hard)                    cntNext = CNT_W'(HOLD_CYCLES);
    else if ((cntQ != '0) && sync2Q) cntNext = cntQ - 1'b1;
    else                             cntNext = cntQ;
  end

  always_ff @(posedge clk or posedge aRst) begin
    if (aRst) begin
      sync1Q <= 1'b0;
      sync2Q <= 1'b0;
      cntQ   <= CNT_W'(HOLD_CYCLES);
      rstNQ  <= 1'b0;
      abortQ <= 1'b0;
      haltQ  <= 1'b0;
    end else begin
      sync1Q <= 1'b1;
      sync2Q <= sync1Q;
      cntQ   <= cntNext;
      rstNQ  <= !stb.hard && (cntNext == '0) && sync2Q;
      abortQ <= stb.abort;
      if (stb.hard)         haltQ <= 1'b0;
      else if (stb.haltSet) haltQ <= 1'b1;
      else if (stb.haltClr) haltQ <= 1'b0;
    end
  end

  assign rstNOut  = rstNQ;
  assign abortOut = abortQ;
  assign haltOut  = haltQ;

  // low-time tracker for the hold check
  logic [CNT_W-1:0] lowRunQ;
  always_ff @(posedge clk or posedge aRst) begin
    if (aRst)                lowRunQ <= '0;
    else if (rstNQ)          lowRunQ <= '0;
    else if (lowRunQ != CNT_W'(HOLD_CYCLES)) lowRunQ <= lowRunQ + 1'b1;
  end

  assert_hold_len_R3: assert property (@(posedge clk) disable iff (aRst)
    $rose(rstNQ) |-> (lowRunQ == CNT_W'(HOLD_CYCLES)));
  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (aRst)
    (abortQ && !stb.abort) |=> !abortQ);
  assert_halt_keep_R5: assert property (@(posedge clk) disable iff (aRst)
    (haltQ && !stb.hard && !stb.haltClr) |=> haltQ);

endmodule

// File: rtl/rah_datapath.sv
module rah_datapath
  import reset_action_pkg::*;
#(
  parameter int NUM_SUBS    = 4,
  parameter int HOLD_CYCLES = 16
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                syncEn,
  input  strobe_t             strobes [NUM_SUBS],
  input  logic [NUM_SUBS-1:0] asyncHit,
  output logic [NUM_SUBS-1:0] subHardRstN,
  output logic [NUM_SUBS-1:0] subAbort,
  output logic [NUM_SUBS-1:0] subHalt
);

  for (genvar s = 0; s < NUM_SUBS; s++) begin : gChan
    rah_sub_chan #(.HOLD_CYCLES(HOLD_CYCLES)) u_chan (
      .clk      (clk),
      .aRst     (asyncHit[s]),
      .stb      (strobes[s]),
      .rstNOut  (subHardRstN[s]),
      .abortOut (subAbort[s]),
      .haltOut  (subHalt[s])
    );

    assert_halt_enable_R6: assert property (@(posedge clk) disable iff (!porN)
      $rose(subHalt[s]) |-> $past(syncEn));
  end

  assert_por_all_R8: assert property (@(posedge clk)
    !porN |-> ((subHardRstN == '0) && (subAbort == '0) && (subHalt == '0)));

endmodule

// File: rtl/reset_action_hub.sv
module reset_action_hub
  import reset_action_pkg::*;
#(
  parameter int NUM_SUBS    = 4,
  parameter int NUM_EVT     = 4,
  parameter int HOLD_CYCLES = 16,
  parameter int ADDR_W      = 4,
  localparam int CMD_W      = 4 * NUM_SUBS,
  localparam int MAP_W      = 2 * NUM_SUBS
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                syncEn,
  input  logic [NUM_EVT-1:0]  sysEvt,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CMD_W-1:0]    regWdata,
  output logic [MAP_W-1:0]    regRdata,
  output logic [NUM_SUBS-1:0] subHardRstN,
  output logic [NUM_SUBS-1:0] subAbort,
  output logic [NUM_SUBS-1:0] subHalt
);

  strobe_t             strobes [NUM_SUBS];
  logic [NUM_SUBS-1:0] asyncHit;

  rah_ctrl #(
    .NUM_SUBS (NUM_SUBS),
    .NUM_EVT  (NUM_EVT),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .syncEn   (syncEn),
    .sysEvt   (sysEvt),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobes  (strobes),
    .asyncHit (asyncHit)
  );

  rah_datapath #(
    .NUM_SUBS    (NUM_SUBS),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dp (
    .clk         (clk),
    .porN        (porN),
    .syncEn      (syncEn),
    .strobes     (strobes),
    .asyncHit    (asyncHit),
    .subHardRstN (subHardRstN),
    .subAbort    (subAbort),
    .subHalt     (subHalt)
  );

endmodule

// File: tb/reset_action_hub_bench.sv
module reset_action_hub_bench;

  localparam int NS   = 4;
  localparam int HOLD = 16;
  localparam int ROWS = 5;

  logic        clk = 1'b0;
  logic        clkRun = 1'b1;
  logic        porN = 1'b1;
  logic        syncEn = 1'b1;
  logic [3:0]  sysEvt = '0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [7:0]  regRdata;
  logic [3:0]  subHardRstN, subAbort, subHalt;

  int checks = 0;
  int errors = 0;

  reset_action_hub u_reset_action_hub (
    .clk(clk), .porN(porN), .syncEn(syncEn), .sysEvt(sysEvt),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .subHardRstN(subHardRstN), .subAbort(subAbort), .subHalt(subHalt)
  );

  always begin
    #5;
    if (clkRun) clk = ~clk;
  end

  // ---------------- reference model ----------------
  int mCnt [NS];
  bit mQ1 [NS], mQ2 [NS], mRst [NS], mAb [NS], mHl [NS], mAsy [NS];
  bit mPor;
  int mMap [ROWS][NS];

  function automatic void forceSub(int s);
    mCnt[s] = HOLD; mQ1[s] = 0; mQ2[s] = 0; mRst[s] = 0; mAb[s] = 0; mHl[s] = 0;
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int s = 0; s < NS; s++) begin forceSub(s); mAsy[s] = 0; end
      mPor = 0;
      for (int r = 0; r < ROWS; r++) for (int s = 0; s < NS; s++) mMap[r][s] = 3;
    end else begin
      int sev [NS];
      bit evts [ROWS];
      bit wCmd, wAsy, wPor, wEvt, nPor, oq2;
      bit nAsy [NS];
      wCmd = regWe && regAddr == 8;
      wAsy = regWe && regAddr == 9;
      wPor = regWe && regAddr == 10 && regWdata[0];
      wEvt = regWe && regAddr == 11 && regWdata[0];
      for (int r = 0; r < 4; r++) evts[r] = sysEvt[r];
      evts[4] = wEvt;
      for (int s = 0; s < NS; s++) begin
        sev[s] = 0;
        for (int r = 0; r < ROWS; r++) if (evts[r] && mMap[r][s] > sev[s]) sev[s] = mMap[r][s];
        if (wCmd && regWdata[s]) sev[s] = 3;
        if (wCmd && regWdata[NS+s] && sev[s] < 2) sev[s] = 2;
        if (wCmd && regWdata[2*NS+s] && sev[s] < 1) sev[s] = 1;
        if (!syncEn) sev[s] = 0;
      end
      for (int s = 0; s < NS; s++) begin
        if (mAsy[s] || mPor) forceSub(s);
        else begin
          oq2 = mQ2[s];
          mQ2[s] = mQ1[s]; mQ1[s] = 1;
          if (sev[s] == 3) mCnt[s] = HOLD;
          else if (mCnt[s] > 0 && oq2) mCnt[s] = mCnt[s] - 1;
          mRst[s] = (sev[s] != 3) && (mCnt[s] == 0) && oq2;
          mAb[s] = (sev[s] == 2);
          if (sev[s] == 3) mHl[s] = 0;
          else if (sev[s] == 1) mHl[s] = 1;
          else if (wCmd && regWdata[3*NS+s]) mHl[s] = 0;
        end
      end
      if (wPor) begin
        for (int r = 0; r < ROWS; r++) for (int s = 0; s < NS; s++) mMap[r][s] = 3;
      end else if (regWe && regAddr < ROWS) begin
        for (int s = 0; s < NS; s++) mMap[regAddr][s] = int'(regWdata[2*s +: 2]);
      end
      nPor = wPor;
      for (int s = 0; s < NS; s++) nAsy[s] = wAsy && regWdata[s];
      for (int s = 0; s < NS; s++) begin
        mAsy[s] = nAsy[s];
        if (nAsy[s] || nPor) forceSub(s);
      end
      mPor = nPor;
    end
  end

  always @(negedge clk) begin
    for (int s = 0; s < NS; s++) begin
      checks += 3;
      if (subHardRstN[s] !== mRst[s]) begin
        errors++;
        $display("FAIL R3 hard reset sub%0d act %b exp %b at %0t", s, subHardRstN[s], mRst[s], $time);
      end
      if (subAbort[s] !== mAb[s]) begin
        errors++;
        $display("FAIL R4 abort sub%0d act %b exp %b at %0t", s, subAbort[s], mAb[s], $time);
      end
      if (subHalt[s] !== mHl[s]) begin
        errors++;
        $display("FAIL R5 halt sub%0d act %b exp %b at %0t", s, subHalt[s], mHl[s], $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic pulseEvt(input logic [3:0] e);
    sysEvt = e;
    @(negedge clk);
    sysEvt = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic countLow(input int s, output int n);
    n = 0;
    while (subHardRstN[s] == 1'b0 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int n;
    #1 porN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset hard", 32'(subHardRstN), 32'h0);
    chk("R8 reset abort/halt", 32'({subAbort, subHalt}), 32'h0);
    porN = 1'b1;
    repeat (25) @(negedge clk);
    chk("R8 released", 32'(subHardRstN), 32'hF);
    rd(0, rv); chk("R1 default row0", 32'(rv), 32'hFF);
    rd(4, rv); chk("R1 default row4", 32'(rv), 32'hFF);

    // brown-out row: s0 hard, s1 abort, s2 halt, s3 none
    wr(0, 16'h001B);
    rd(0, rv); chk("R1 row0 readback", 32'(rv), 32'h1B);
    pulseEvt(4'b0001);
    chk("R2 brownout hard", 32'(subHardRstN), 32'hE);
    chk("R2 brownout abort", 32'(subAbort), 32'h2);
    chk("R2 brownout halt", 32'(subHalt), 32'h4);
    @(negedge clk);
    chk("R4 abort one cycle", 32'(subAbort), 32'h0);
    repeat (20) @(negedge clk);

    // severity: watchdog + sensor together
    wr(1, 16'h002D);
    wr(2, 16'h0076);
    pulseEvt(4'b0110);
    chk("R2 severity abort", 32'(subAbort), 32'h1);
    chk("R2 severity hard", 32'(subHardRstN), 32'h9);
    chk("R3 hard clears halt", 32'(subHalt), 32'h8);
    repeat (20) @(negedge clk);
    chk("R5 halt kept", 32'(subHalt), 32'h8);
    wr(8, 16'h8000);
    chk("R5 halt cleared", 32'(subHalt), 32'h0);

    // enable low
    syncEn = 1'b0;
    pulseEvt(4'b0110);
    chk("R6 event ignored", 32'({subHardRstN, subAbort, subHalt}), 32'hF00);
    wr(8, 16'h0FFF);
    chk("R6 command ignored", 32'({subHardRstN, subAbort, subHalt}), 32'hF00);
    syncEn = 1'b1;

    // direct firmware command
    wr(8, 16'h0421);
    chk("R7 cmd hard", 32'(subHardRstN), 32'hE);
    chk("R7 cmd abort", 32'(subAbort), 32'h2);
    chk("R7 cmd halt", 32'(subHalt), 32'h4);
    countLow(0, n);
    chk("R3 hold length", 32'(n), 32'(HOLD));
    rd(1, rv); chk("R10 map kept after hard", 32'(rv), 32'h2D);

    // firmware event through row 4
    wr(4, 16'h0080);
    wr(11, 16'h0001);
    chk("R7 fw event abort", 32'(subAbort), 32'h8);
    @(negedge clk);

    // default row 3 is hard everywhere
    pulseEvt(4'b1000);
    chk("R1 default row hard", 32'(subHardRstN), 32'h0);
    repeat (20) @(negedge clk);

    // asynchronous firmware reset with enable low
    syncEn = 1'b0;
    wr(9, 16'h0002);
    chk("R9 async assert", 32'(subHardRstN), 32'hD);
    countLow(1, n);
    chk("R9 async length", 32'(n), 32'(HOLD + 3));
    syncEn = 1'b1;
    repeat (3) @(negedge clk);

    // firmware power-on restart
    wr(8, 16'h0800);
    wr(0, 16'h0000);
    wr(10, 16'h0001);
    chk("R10 all reset", 32'(subHardRstN), 32'h0);
    chk("R10 halt cleared", 32'(subHalt), 32'h0);
    rd(0, rv); chk("R10 map default", 32'(rv), 32'hFF);
    repeat (25) @(negedge clk);
    chk("R10 released", 32'(subHardRstN), 32'hF);

    // power-on with clock stopped
    wr(2, 16'h0000);
    wr(8, 16'h0800);
    clkRun = 1'b0;
    #20 porN = 1'b0;
    #2;
    chk("R8 no-clock assert", 32'(subHardRstN), 32'h0);
    chk("R8 no-clock halt", 32'(subHalt), 32'h0);
    #20 porN = 1'b1;
    #3 clkRun = 1'b1;
    @(negedge clk);
    rd(2, rv); chk("R8 map default", 32'(rv), 32'hFF);
    repeat (25) @(negedge clk);
    chk("R8 released again", 32'(subHardRstN), 32'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule